// File: doc/BRIEF.md
# Audio Processor Mode Controller

This block sequences a stereo filter processor through its operating modes. After a start request it clears its tables and sample histories, then collects the per-group shift counts and the coefficient table in two separate loading phases. Each phase is opened by a frame marker from the serial front end. A third frame marker starts normal processing of audio samples.

While working, the block watches the incoming left and right samples. After a long run in which both channels are zero, it drops into a sleep mode, and the first non-zero sample wakes it. A low level on the flush request moves it into a clearing mode that wipes the sample histories but keeps both tables. When the request is released, the block waits for the next data frame.

The serial deserializer and the arithmetic datapath sit outside the block. The deserializer supplies frame, word and sample strobes. The block drives the write enables and load address for the two table memories, a per-sample compute enable, clear strobes, and the ready handshake back to the controller.

Top module: `audio_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `mode` is 0, `in_ready` is 0, `clr_tables` and `clr_hist` are 1, and `rj_we`, `coef_we` and `compute_en` are 0.
- R2: `start_a` passes through a two-stage synchronizer. Three rising edges after it rises, `mode` is 0 from any mode, and it stays 0 while `start_a` is high. After release, mode 0 lasts `INIT_CYC` more counted cycles and then goes to mode 1.
- R3: A `frame_seen` pulse moves mode 1 to 2, mode 3 to 4 and mode 5 to 6 at the next edge. In every other mode, including mode 0, it has no effect.
- R4: In mode 2 each `word_vld` pulse raises `rj_we` in the same cycle, with `load_addr` counting 0 to `RJ_WORDS-1`. The last word moves the mode to 3. `word_vld` outside modes 2 and 4 raises no write enable.
- R5: In mode 4 each `word_vld` raises `coef_we`, with `load_addr` counting 0 to `COEF_WORDS-1`. The last word moves the mode to 5.
- R6: In mode 6, `compute_en` equals `smp_vld`. At most one of `rj_we`, `coef_we` and `compute_en` is high in any cycle.
- R7: In mode 6, a sample with both channels zero that completes a run of `ZERO_RUN` consecutive all-zero samples moves the mode to 8. Any sample with a non-zero channel restarts the run. The run count saturates at `ZERO_RUN`.
- R8: In mode 8, an all-zero sample gives no `compute_en` and the mode stays 8. A sample with either channel non-zero raises `compute_en` in that cycle and moves the mode back to 6.
- R9: `flush_n` low in mode 6 or 8 moves the mode to 7 at the next edge. The mode stays 7 while `flush_n` is low and goes to 5 once it is high. Entering mode 7 restarts the zero run.
- R10: `in_ready` is 1 exactly in modes 1 to 6 and 0 in modes 0, 7 and 8.
- R11: `clr_tables` is 1 only in mode 0. `clr_hist` is 1 in modes 0 and 7, so a flush keeps both tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_a | input | 1 | Start request, asynchronous |
| flush_n | input | 1 | Flush request, active low, system-clock domain |
| frame_seen | input | 1 | One-cycle pulse: frame marker received |
| word_vld | input | 1 | One-cycle pulse: table word received |
| smp_vld | input | 1 | One-cycle pulse: stereo sample pair received |
| smp_l | input | SMP_W | Left channel sample |
| smp_r | input | SMP_W | Right channel sample |
| mode | output | 4 | Current mode code, 0 to 8 |
| in_ready | output | 1 | Ready to accept data from the controller |
| rj_we | output | 1 | Shift-count table write enable |
| coef_we | output | 1 | Coefficient table write enable |
| load_addr | output | ADDR_W | Table write address |
| compute_en | output | 1 | Process the current sample pair |
| clr_tables | output | 1 | Clear both tables |
| clr_hist | output | 1 | Clear sample histories |

## Verification
The properties assume that `frame_seen`, `word_vld` and `smp_vld` are single-cycle pulses already in the system-clock domain, and that `flush_n` is never low during a loading phase. The bench drives each strobe for exactly one cycle through tasks. It releases `flush_n` only while the block is working or clearing, and changes `start_a` only between clock edges, so the synchronizer latency stays fixed at two stages.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [3:0] {
        M_INIT      = 4'd0,
        M_WAIT_RJ   = 4'd1,
        M_LOAD_RJ   = 4'd2,
        M_WAIT_COEF = 4'd3,
        M_LOAD_COEF = 4'd4,
        M_WAIT_IN   = 4'd5,
        M_RUN       = 4'd6,
        M_FLUSH     = 4'd7,
        M_SLEEP     = 4'd8
    } mode_e;

    typedef struct packed {
        logic tables;
        logic hist;
    } clr_t;

    typedef struct packed {
        logic rj;
        logic coef;
        logic comp;
    } en_t;

    function automatic logic mode_ready(mode_e m);
        return (m != M_INIT) && (m != M_FLUSH) && (m != M_SLEEP);
    endfunction

    function automatic int unsigned idx_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/amc_sync2.sv
module amc_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= din;
            hold_q <= meta_q;
        end
    end

    assign dout = hold_q;
endmodule

// File: rtl/amc_step_cnt.sv
module amc_step_cnt #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned IDX_W = amc_pkg::idx_width(LIMIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (inc) begin
            idx <= (idx == TOP) ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/amc_zero_run.sv
module amc_zero_run #(
    parameter int unsigned RUN_LEN = 800,
    parameter int unsigned CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             vld,
    input  logic             quiet,
    output logic [CNT_W-1:0] cnt,
    output logic             run_done
);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (vld) begin
            if (!quiet) begin
                cnt <= '0;
            end else if (cnt != SAT) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign run_done = vld && quiet && (cnt == LAST);
endmodule

// File: rtl/audio_mode_ctrl.sv
module audio_mode_ctrl
    import amc_pkg::*;
#(
    parameter int unsigned SMP_W      = 16,
    parameter int unsigned RJ_WORDS   = 16,
    parameter int unsigned COEF_WORDS = 512,
    parameter int unsigned ZERO_RUN   = 800,
    parameter int unsigned INIT_CYC   = 8,
    localparam int unsigned ADDR_W    = idx_width((COEF_WORDS > RJ_WORDS) ? COEF_WORDS : RJ_WORDS),
    localparam int unsigned RJ_W      = idx_width(RJ_WORDS),
    localparam int unsigned COEF_W    = idx_width(COEF_WORDS),
    localparam int unsigned INIT_W    = idx_width(INIT_CYC),
    localparam int unsigned ZC_W      = $clog2(ZERO_RUN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_a,
    input  logic              flush_n,
    input  logic              frame_seen,
    input  logic              word_vld,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic [SMP_W-1:0]  smp_r,
    output logic [3:0]        mode,
    output logic              in_ready,
    output logic              rj_we,
    output logic              coef_we,
    output logic [ADDR_W-1:0] load_addr,
    output logic              compute_en,
    output logic              clr_tables,
    output logic              clr_hist
);

    mode_e            state_q, state_d;
    logic             start_s;
    logic [INIT_W-1:0] init_idx;
    logic [RJ_W-1:0]   rj_idx;
    logic [COEF_W-1:0] coef_idx;
    logic [ZC_W-1:0]   zcnt;
    logic              run_done;
    logic              quiet;
    logic              init_last, rj_last, coef_last;
    en_t               en;
    clr_t              clr;

    amc_sync2 u_start_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (start_a),
        .dout (start_s)
    );

    amc_step_cnt #(.LIMIT(INIT_CYC)) u_init_cnt (
        .clk (clk),
        .rst (rst),
        .clr (start_s || (state_q != M_INIT)),
        .inc (state_q == M_INIT),
        .idx (init_idx)
    );

    amc_step_cnt #(.LIMIT(RJ_WORDS)) u_rj_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_q == M_INIT),
        .inc (en.rj),
        .idx (rj_idx)
    );

    amc_step_cnt #(.LIMIT(COEF_WORDS)) u_coef_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_q == M_INIT),
        .inc (en.coef),
        .idx (coef_idx)
    );

    assign quiet = (smp_l == '0) && (smp_r == '0);

    amc_zero_run #(.RUN_LEN(ZERO_RUN)) u_zero (
        .clk      (clk),
        .rst      (rst),
        .clr      ((state_q == M_INIT) || (state_q == M_FLUSH)),
        .vld      (smp_vld && ((state_q == M_RUN) || (state_q == M_SLEEP))),
        .quiet    (quiet),
        .cnt      (zcnt),
        .run_done (run_done)
    );

    assign init_last = !start_s && (init_idx == INIT_W'(INIT_CYC - 1));
    assign rj_last   = en.rj   && (rj_idx   == RJ_W'(RJ_WORDS - 1));
    assign coef_last = en.coef && (coef_idx == COEF_W'(COEF_WORDS - 1));

    always_comb begin
        en.rj   = word_vld && (state_q == M_LOAD_RJ);
        en.coef = word_vld && (state_q == M_LOAD_COEF);
        en.comp = smp_vld && ((state_q == M_RUN) || ((state_q == M_SLEEP) && !quiet));
    end

    always_comb begin
        clr.tables = (state_q == M_INIT);
        clr.hist   = (state_q == M_INIT) || (state_q == M_FLUSH);
    end

    always_comb begin
        state_d = state_q;
        if (start_s) begin
            state_d = M_INIT;
        end else begin
            unique case (state_q)
                M_INIT:      if (init_last)  state_d = M_WAIT_RJ;
                M_WAIT_RJ:   if (frame_seen) state_d = M_LOAD_RJ;
                M_LOAD_RJ:   if (rj_last)    state_d = M_WAIT_COEF;
                M_WAIT_COEF: if (frame_seen) state_d = M_LOAD_COEF;
                M_LOAD_COEF: if (coef_last)  state_d = M_WAIT_IN;
                M_WAIT_IN:   if (frame_seen) state_d = M_RUN;
                M_RUN: begin
                    if (!flush_n)      state_d = M_FLUSH;
                    else if (run_done) state_d = M_SLEEP;
                end
                M_SLEEP: begin
                    if (!flush_n)                  state_d = M_FLUSH;
                    else if (smp_vld && !quiet)    state_d = M_RUN;
                end
                M_FLUSH:     if (flush_n)    state_d = M_WAIT_IN;
                default:                     state_d = M_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= M_INIT;
        else     state_q <= state_d;
    end

    assign mode       = state_q;
    assign in_ready   = mode_ready(state_q);
    assign rj_we      = en.rj;
    assign coef_we    = en.coef;
    assign compute_en = en.comp;
    assign clr_tables = clr.tables;
    assign clr_hist   = clr.hist;
    assign load_addr  = (state_q == M_LOAD_RJ) ? ADDR_W'(rj_idx) : ADDR_W'(coef_idx);

endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
    parameter int unsigned ZERO_RUN = 800,
    parameter int unsigned ZC_W     = 10
) (
    input logic            clk,
    input logic            rst,
    input logic            start_s,
    input logic            flush_n,
    input logic            frame_seen,
    input logic [3:0]      mode,
    input logic            rj_we,
    input logic            coef_we,
    input logic            compute_en,
    input logic            clr_tables,
    input logic [ZC_W-1:0] zcnt
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= 1'b1;
    end

    // R2
    start_force_chk: assert property (@(posedge clk) disable iff (rst)
        start_s |=> (mode == 4'd0));

    // R3
    frame_rj_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd1 && frame_seen && !start_s) |=> (mode == 4'd2));

    // R4
    rj_we_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rj_we |-> (mode == 4'd2));

    // R5
    coef_we_mode_chk: assert property (@(posedge clk) disable iff (rst)
        coef_we |-> (mode == 4'd4));

    // R6
    en_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rj_we, coef_we, compute_en}));

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && mode == 4'd8 && $past(mode) != 4'd8) |-> ($past(mode) == 4'd6));

    // R7
    zero_sat_chk: assert property (@(posedge clk) disable iff (rst)
        zcnt <= ZC_W'(ZERO_RUN));

    // R9
    flush_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!flush_n && !start_s && (mode == 4'd6 || mode == 4'd8)) |=> (mode == 4'd7));

    // R11
    tables_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'd7) |-> !clr_tables);
endmodule

bind audio_mode_ctrl amc_chk #(.ZERO_RUN(ZERO_RUN), .ZC_W(ZC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_s    (start_s),
    .flush_n    (flush_n),
    .frame_seen (frame_seen),
    .mode       (mode),
    .rj_we      (rj_we),
    .coef_we    (coef_we),
    .compute_en (compute_en),
    .clr_tables (clr_tables),
    .zcnt       (zcnt)
);

// File: tb/audio_mode_ctrl_bench.sv
module audio_mode_ctrl_bench;
    localparam int SMP_W      = 16;
    localparam int RJ_WORDS   = 16;
    localparam int COEF_WORDS = 512;
    localparam int ZERO_RUN   = 800;
    localparam int INIT_CYC   = 8;
    localparam int ADDR_W     = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_a = 1'b0, flush_n = 1'b1, frame_seen = 1'b0, word_vld = 1'b0, smp_vld = 1'b0;
    logic [SMP_W-1:0] smp_l = '0, smp_r = '0;
    logic [3:0] mode;
    logic in_ready, rj_we, coef_we, compute_en, clr_tables, clr_hist;
    logic [ADDR_W-1:0] load_addr;

    int n_chk = 0;
    int n_err = 0;
    int    exp_q[$];
    string tag_q[$];
    logic [3:0] prev_mode = 4'd0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    audio_mode_ctrl u_audio_mode_ctrl (
        .clk(clk), .rst(rst), .start_a(start_a), .flush_n(flush_n),
        .frame_seen(frame_seen), .word_vld(word_vld), .smp_vld(smp_vld),
        .smp_l(smp_l), .smp_r(smp_r), .mode(mode), .in_ready(in_ready),
        .rj_we(rj_we), .coef_we(coef_we), .load_addr(load_addr),
        .compute_en(compute_en), .clr_tables(clr_tables), .clr_hist(clr_hist)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic push(int m, string tag);
        exp_q.push_back(m);
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every mode change must match the next queued item
    always @(negedge clk) begin
        if (!rst && mode !== prev_mode) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_err++;
                $display("FAIL unexpected mode change (R2..R9): act=%0d exp=%0d", mode, prev_mode);
            end else begin
                check(tag_q.pop_front(), int'(mode), exp_q.pop_front());
            end
            prev_mode = mode;
        end
    end

    task automatic pulse_frame();
        @(negedge clk); frame_seen = 1'b1;
        @(posedge clk); #1 frame_seen = 1'b0;
    endtask

    task automatic send_word(int exp_rj, int exp_coef, int exp_addr, string req);
        @(negedge clk); word_vld = 1'b1;
        #1;
        check(req, int'(rj_we), exp_rj);
        check(req, int'(coef_we), exp_coef);
        if (exp_rj == 1 || exp_coef == 1) check(req, int'(load_addr), exp_addr);
        @(posedge clk); #1 word_vld = 1'b0;
    endtask

    task automatic send_smp(logic [SMP_W-1:0] l, logic [SMP_W-1:0] r, int exp_ce, string req);
        @(negedge clk); smp_vld = 1'b1; smp_l = l; smp_r = r;
        #1 check(req, int'(compute_en), exp_ce);
        @(posedge clk); #1 smp_vld = 1'b0; smp_l = '0; smp_r = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1..R11: act=%0d exp=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", int'(mode), 0);
        check("R1", int'(in_ready), 0);
        check("R1", int'(clr_tables), 1);
        check("R1", int'(clr_hist), 1);
        check("R1", int'(rj_we | coef_we | compute_en), 0);
        rst = 1'b0;

        push(1, "R2");
        pulse_frame();                 // R3: frame in mode 0 ignored
        check("R3", int'(mode), 0);
        repeat (INIT_CYC + 4) @(negedge clk);
        check("R2", int'(mode), 1);
        check("R10", int'(in_ready), 1);
        check("R11", int'(clr_tables), 0);

        send_word(0, 0, 0, "R4");      // word in mode 1 ignored
        check("R4", int'(mode), 1);

        push(2, "R3");
        pulse_frame();
        for (int i = 0; i < RJ_WORDS; i++) begin
            if (i == RJ_WORDS - 1) push(3, "R4");
            send_word(1, 0, i, "R4");
        end
        @(negedge clk);
        check("R4", int'(mode), 3);

        push(4, "R3");
        pulse_frame();
        for (int i = 0; i < COEF_WORDS; i++) begin
            if (i == COEF_WORDS - 1) push(5, "R5");
            send_word(0, 1, i, "R5");
        end
        @(negedge clk);
        check("R5", int'(mode), 5);

        push(6, "R3");
        pulse_frame();
        send_smp(16'd5, 16'd0, 1, "R6");
        for (int i = 0; i < ZERO_RUN - 1; i++) send_smp('0, '0, 1, "R6");
        send_smp(16'd0, 16'd1, 1, "R7");   // breaks the run
        check("R7", int'(mode), 6);
        for (int i = 0; i < ZERO_RUN; i++) begin
            if (i == ZERO_RUN - 1) push(8, "R7");
            send_smp('0, '0, 1, "R7");
        end
        @(negedge clk);
        check("R7", int'(mode), 8);
        check("R10", int'(in_ready), 0);

        send_smp('0, '0, 0, "R8");
        check("R8", int'(mode), 8);
        push(6, "R8");
        send_smp('0, 16'h8000, 1, "R8");

        for (int i = 0; i < 500; i++) send_smp('0, '0, 1, "R6");
        push(7, "R9");
        @(negedge clk); flush_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", int'(mode), 7);
        check("R11", int'(clr_hist), 1);
        check("R11", int'(clr_tables), 0);
        check("R10", int'(in_ready), 0);
        push(5, "R9");
        flush_n = 1'b1;
        @(negedge clk);
        check("R9", int'(mode), 5);

        push(6, "R3");
        pulse_frame();
        for (int i = 0; i < ZERO_RUN; i++) begin
            if (i == ZERO_RUN - 1) push(8, "R9");
            send_smp('0, '0, 1, "R9");
        end
        @(negedge clk);
        check("R9", int'(mode), 8);

        push(0, "R2");
        start_a = 1'b1;
        repeat (5) @(negedge clk);
        check("R2", int'(mode), 0);
        check("R11", int'(clr_tables), 1);
        push(1, "R2");
        start_a = 1'b0;
        repeat (INIT_CYC + 6) @(negedge clk);
        check("R2", int'(mode), 1);
        check("R2", exp_q.size(), 0);

        done = 1'b1;
        finish_run();
    end
endmodule